// File: doc/BRIEF.md
# Multi-Core Hardware Semaphore Unit

This block holds a bank of hardware semaphores that several bus masters use to guard shared resources. Each access on the register bus carries the master's core ID, and that ID is what the hardware records as a semaphore's owner. A master can take a semaphore in one of two ways. It can write a lock request that carries a process ID and then read the register back to confirm ownership. Or it can read a separate read-lock address, which takes the semaphore when it is free and returns the resulting state in the same access.

Release is protected. A plain unlock write frees a semaphore only when the writing master and the written process ID both match the owner. A keyed clear register frees every semaphore that one core holds in a single write, provided the 16-bit key matches the programmed key. Every release can raise a per-core interrupt status bit. Each core has its own enable, status and write-1-to-clear registers, and one interrupt line that goes high when any enabled status bit is set.

Read data appears on `bus_rdata` in the cycle after the read request and holds until the next read.

Top module: `hwsem_bank`

## Requirements
- R1: After a synchronous active-low reset, all semaphores are free, the key is 0, every enable and status bit is 0, every `irq` line is low, and every main register reads 0.
- R2: A write to word address i (0..31) with bit 31 = 1 takes a free semaphore i. The hardware records the bus master ID and the process ID from bits 7:0. A read of address i then returns bit 31 = 1, the owner core ID in bits 11:8 and the owner process ID in bits 7:0. All other bits are 0, and a free semaphore reads as all zeros.
- R3: A lock write (bit 31 = 1) to a semaphore that is already held leaves its owner and process ID unchanged, whoever the writer is.
- R4: A read of word address 32+i, when semaphore i is free, takes it for the reading master with process ID 0. The read returns 0x8000_0000 with the master ID in bits 11:8.
- R5: A read of address 32+i, when semaphore i is held, changes nothing and returns the current owner state. If the reader is the owner, it therefore sees its own core ID with bit 31 set.
- R6: A write with bit 31 = 0 to address i frees semaphore i only when the bus master ID equals the owner core ID and bits 7:0 equal the owner process ID. Any other unlock write leaves the semaphore unchanged.
- R7: The key register at word address 0x61 holds a 16-bit key in bits 31:16. It is writable and reads back in bits 31:16, with the lower bits reading 0.
- R8: A write to the clear register at word address 0x60 with bits 31:16 equal to the key frees every semaphore whose owner core ID equals bits 11:8, and no other semaphore. With any other key value it changes nothing.
- R9: For core c (0..3), the enable register is at word address 0x40+4c and the status register at 0x42+4c, with bit i referring to semaphore i. When a semaphore is released by unlock or bulk clear, status bit i is set for each core whose enable bit i is set, and for no other core.
- R10: Writing a 1 to bit i at word address 0x41+4c clears status bit i of core c, and bits written as 0 are left alone. `irq[c]` is high exactly when status and enable of core c share a set bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_valid | input | 1 | Access request in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_master | input | 4 | Core ID of the requesting master |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| irq | output | NUM_CORES | Per-core interrupt line |

## Verification
The bench locks most of the bank from several masters and then replays hostile traffic against every held semaphore. This traffic includes lock writes from other cores, unlocks with a wrong process ID and unlocks from a wrong master. A design that let any of these through would show a changed owner in the read-back. One-step reads are aimed both at free slots and at slots held by the reader and by other cores, so a design that overwrote a held semaphore, or reported a nonzero process ID on a fresh one-step lock, fails the comparison. Bulk clear is tried with a wrong key and then with the right key, and only one core's semaphores may go free. The interrupt status of all four cores is compared after each release, so routing a release to a core with its enable bit clear, or clearing bits written as 0, is caught.

// File: rtl/hwsem_pkg.sv
// Shared layout constants, owner state type and read-value packing for the
// semaphore bank. Assumes 32-bit data and at most 32 semaphores per bank.
package hwsem_pkg;
    localparam int CID_W  = 4;
    localparam int PID_W  = 8;
    localparam int ADDR_W = 7;
    localparam int DATA_W = 32;
    localparam int KEY_W  = 16;

    localparam logic [ADDR_W-1:0] RL_BASE  = 7'h20;
    localparam logic [ADDR_W-1:0] IRQ_BASE = 7'h40;
    localparam logic [ADDR_W-1:0] CLR_ADDR = 7'h60;
    localparam logic [ADDR_W-1:0] KEY_ADDR = 7'h61;
    localparam int IRQ_STRIDE = 4;
    localparam int IER_OFS    = 0;
    localparam int ICR_OFS    = 1;
    localparam int ISR_OFS    = 2;

    typedef struct packed {
        logic             lock;
        logic [CID_W-1:0] cid;
        logic [PID_W-1:0] pid;
    } sem_state_t;

    // Register image of one semaphore: a free slot reads as zero.
    function automatic logic [DATA_W-1:0] pack_sem(sem_state_t s);
        if (s.lock)
            return {1'b1, {(DATA_W-1-CID_W-PID_W){1'b0}}, s.cid, s.pid};
        return '0;
    endfunction
endpackage

// File: rtl/hwsem_decode.sv
// Address decoder: turns one bus access into per-target strobes.
// Assumes at most one access per cycle and NUM_SEM <= 32, NUM_CORES <= 8.
module hwsem_decode
    import hwsem_pkg::*;
#(
    parameter int NUM_SEM   = 32,
    parameter int NUM_CORES = 4
) (
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_SEM-1:0]   sem_wr,
    output logic [NUM_SEM-1:0]   rl_rd,
    output logic [NUM_CORES-1:0] ier_wr,
    output logic [NUM_CORES-1:0] icr_wr,
    output logic                 clr_wr,
    output logic                 key_wr
);
    logic wr_any;
    logic rd_any;

    assign wr_any = valid && write;
    assign rd_any = valid && !write;

    // One main-register write strobe and one read-lock strobe per semaphore.
    for (genvar i = 0; i < NUM_SEM; i++) begin : g_sem
        assign sem_wr[i] = wr_any && (addr == ADDR_W'(i));
        assign rl_rd[i]  = rd_any && (addr == RL_BASE + ADDR_W'(i));
    end

    // Per-core enable and clear write strobes.
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        assign ier_wr[c] = wr_any && (addr == IRQ_BASE + ADDR_W'(c*IRQ_STRIDE + IER_OFS));
        assign icr_wr[c] = wr_any && (addr == IRQ_BASE + ADDR_W'(c*IRQ_STRIDE + ICR_OFS));
    end

    assign clr_wr = wr_any && (addr == CLR_ADDR);
    assign key_wr = wr_any && (addr == KEY_ADDR);
endmodule

// File: rtl/hwsem_slot.sv
// One semaphore: owner state plus the lock, unlock, one-step and bulk-free
// rules. Assumes the strobes are mutually exclusive (one access per cycle).
// release_evt pulses in the cycle a held semaphore is freed.
module hwsem_slot
    import hwsem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_lock,
    input  logic [PID_W-1:0] wr_pid,
    input  logic             rl_en,
    input  logic [CID_W-1:0] req_cid,
    input  logic             clr_en,
    input  logic [CID_W-1:0] clr_cid,
    output sem_state_t       state,
    output logic             release_evt
);
    logic owner_match;
    logic unlock_ok;
    logic bulk_hit;

    assign owner_match = state.lock && (state.cid == req_cid) && (state.pid == wr_pid);
    assign unlock_ok   = wr_en && !wr_lock && owner_match;
    assign bulk_hit    = clr_en && state.lock && (state.cid == clr_cid);
    assign release_evt = unlock_ok || bulk_hit;

    // Owner state update: take when free, free on checked unlock or bulk hit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= '0;
        end else if (wr_en && wr_lock && !state.lock) begin
            state <= '{lock: 1'b1, cid: req_cid, pid: wr_pid};
        end else if (unlock_ok || bulk_hit) begin
            state <= '0;
        end else if (rl_en && !state.lock) begin
            state <= '{lock: 1'b1, cid: req_cid, pid: '0};
        end
    end

    // R3
    lock_held_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_lock && state.lock) |=> $stable(state));

    // R6
    unlock_mismatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_lock && state.lock &&
         ((state.cid != req_cid) || (state.pid != wr_pid))) |=> $stable(state));

    // R4
    onestep_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rl_en && !state.lock) |=>
        (state.lock && (state.pid == '0) && (state.cid == $past(req_cid))));

    // R8
    bulk_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && state.lock && (state.cid == clr_cid)) |=> !state.lock);
endmodule

// File: rtl/hwsem_irq.sv
// Interrupt bank of one core: enable mask, sticky status set by releases,
// write-1-to-clear, and the masked OR to the interrupt line.
// Assumes releases and clear writes never fall in the same cycle.
module hwsem_irq #(
    parameter int NUM_SEM = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ier_wr,
    input  logic               icr_wr,
    input  logic [NUM_SEM-1:0] wdata,
    input  logic [NUM_SEM-1:0] rel,
    output logic [NUM_SEM-1:0] ier,
    output logic [NUM_SEM-1:0] isr,
    output logic               irq
);
    logic [NUM_SEM-1:0] clr_mask;

    assign clr_mask = icr_wr ? wdata : '0;
    assign irq      = |(isr & ier);

    // Enable mask register.
    always_ff @(posedge clk) begin
        if (!rst_n)      ier <= '0;
        else if (ier_wr) ier <= wdata;
    end

    // Sticky status: set by enabled releases, cleared by written ones.
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~clr_mask) | (rel & ier);
    end

    // R9
    rel_sets_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(rel & ier)) |=> ((isr & $past(rel & ier)) == $past(rel & ier)));

    // R10
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icr_wr |=> ((isr & $past(wdata)) == '0));
endmodule

// File: rtl/hwsem_bank.sv
// Top of the semaphore bank: decoder, one slot per semaphore, one interrupt
// bank per core, key register, bulk release and registered read data.
// Assumes a single access per cycle; read data is valid the next cycle.
module hwsem_bank
    import hwsem_pkg::*;
#(
    parameter int NUM_SEM   = 32,
    parameter int NUM_CORES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    input  logic [CID_W-1:0]     bus_master,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_CORES-1:0] irq
);
    localparam int SEL_W = (NUM_SEM > 1) ? $clog2(NUM_SEM) : 1;

    logic [NUM_SEM-1:0]   sem_wr;
    logic [NUM_SEM-1:0]   rl_rd;
    logic [NUM_CORES-1:0] ier_wr;
    logic [NUM_CORES-1:0] icr_wr;
    logic                 clr_wr;
    logic                 key_wr;
    logic                 bulk_go;
    logic [KEY_W-1:0]     key_q;
    sem_state_t           st [NUM_SEM];
    logic [NUM_SEM-1:0]   rel;
    logic [NUM_SEM-1:0]   lock_vec;
    logic [NUM_SEM-1:0]   ier_a [NUM_CORES];
    logic [NUM_SEM-1:0]   isr_a [NUM_CORES];
    logic [SEL_W-1:0]     sem_idx;
    logic [DATA_W-1:0]    rd_next;
    sem_state_t           rl_taken;

    hwsem_decode #(.NUM_SEM(NUM_SEM), .NUM_CORES(NUM_CORES)) u_decode (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .sem_wr(sem_wr),
        .rl_rd (rl_rd),
        .ier_wr(ier_wr),
        .icr_wr(icr_wr),
        .clr_wr(clr_wr),
        .key_wr(key_wr)
    );

    assign bulk_go = clr_wr && (bus_wdata[DATA_W-1 -: KEY_W] == key_q);

    for (genvar i = 0; i < NUM_SEM; i++) begin : g_slot
        hwsem_slot u_slot (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (sem_wr[i]),
            .wr_lock    (bus_wdata[DATA_W-1]),
            .wr_pid     (bus_wdata[PID_W-1:0]),
            .rl_en      (rl_rd[i]),
            .req_cid    (bus_master),
            .clr_en     (bulk_go),
            .clr_cid    (bus_wdata[8 +: CID_W]),
            .state      (st[i]),
            .release_evt(rel[i])
        );
        assign lock_vec[i] = st[i].lock;
    end

    for (genvar c = 0; c < NUM_CORES; c++) begin : g_irq
        hwsem_irq #(.NUM_SEM(NUM_SEM)) u_irq (
            .clk   (clk),
            .rst_n (rst_n),
            .ier_wr(ier_wr[c]),
            .icr_wr(icr_wr[c]),
            .wdata (bus_wdata[NUM_SEM-1:0]),
            .rel   (rel),
            .ier   (ier_a[c]),
            .isr   (isr_a[c]),
            .irq   (irq[c])
        );
    end

    // Programmable bulk-release key.
    always_ff @(posedge clk) begin
        if (!rst_n)      key_q <= '0;
        else if (key_wr) key_q <= bus_wdata[DATA_W-1 -: KEY_W];
    end

    assign sem_idx  = bus_addr[SEL_W-1:0];
    assign rl_taken = '{lock: 1'b1, cid: bus_master, pid: '0};

    // Read multiplexer: state after the access for read-lock reads.
    always_comb begin
        rd_next = '0;
        if (bus_addr < ADDR_W'(NUM_SEM)) begin
            rd_next = pack_sem(st[sem_idx]);
        end else if (bus_addr >= RL_BASE && bus_addr < RL_BASE + ADDR_W'(NUM_SEM)) begin
            rd_next = st[sem_idx].lock ? pack_sem(st[sem_idx]) : pack_sem(rl_taken);
        end else if (bus_addr == KEY_ADDR) begin
            rd_next = {key_q, {(DATA_W-KEY_W){1'b0}}};
        end else begin
            for (int c = 0; c < NUM_CORES; c++) begin
                if (bus_addr == IRQ_BASE + ADDR_W'(c*IRQ_STRIDE + IER_OFS))
                    rd_next = DATA_W'(ier_a[c]);
                if (bus_addr == IRQ_BASE + ADDR_W'(c*IRQ_STRIDE + ISR_OFS))
                    rd_next = DATA_W'(isr_a[c]);
            end
        end
    end

    // Registered read data, held between reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                       bus_rdata <= '0;
        else if (bus_valid && !bus_write) bus_rdata <= rd_next;
    end

    // R8
    badkey_noeffect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (bus_wdata[DATA_W-1 -: KEY_W] != key_q)) |=> $stable(lock_vec));

    // R7
    key_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_wr |=> (key_q == $past(bus_wdata[DATA_W-1 -: KEY_W])));
endmodule

// File: tb/hwsem_bank_bench.sv
// Self-checking bench: sweeps the bank against an arithmetic model.
module hwsem_bank_bench;
    localparam int NS = 32;
    localparam int NC = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_master = '0;
    logic [31:0] bus_rdata;
    logic [NC-1:0] irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    bit          m_lk [NS];
    logic [3:0]  m_c  [NS];
    logic [7:0]  m_p  [NS];
    logic [31:0] m_ier [NC];
    logic [31:0] m_isr [NC];
    logic [15:0] m_key;

    always #5 clk = ~clk;

    hwsem_bank u_hwsem_bank (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_master(bus_master),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] img(int i);
        return m_lk[i] ? {1'b1, 19'b0, m_c[i], m_p[i]} : 32'h0;
    endfunction

    function automatic logic [31:0] exp_irq();
        logic [31:0] v = '0;
        for (int c = 0; c < NC; c++) v[c] = |(m_isr[c] & m_ier[c]);
        return v;
    endfunction

    task automatic m_free(int i);
        m_lk[i] = 1'b0; m_c[i] = '0; m_p[i] = '0;
        for (int c = 0; c < NC; c++) if (m_ier[c][i]) m_isr[c][i] = 1'b1;
    endtask

    task automatic bus_wr(input logic [3:0] mid, input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_master = mid;
        @(posedge clk); #1;
        bus_valid = 1'b0;
        // model update
        if (a < 7'd32) begin
            if (d[31]) begin
                if (!m_lk[a]) begin m_lk[a] = 1'b1; m_c[a] = mid; m_p[a] = d[7:0]; end
            end else if (m_lk[a] && m_c[a] == mid && m_p[a] == d[7:0]) begin
                m_free(int'(a));
            end
        end else if (a >= 7'h40 && a < 7'h50) begin
            if ((a - 7'h40) % 4 == 0) m_ier[(a - 7'h40) / 4] = d;
            if ((a - 7'h40) % 4 == 1) m_isr[(a - 7'h40) / 4] &= ~d;
        end else if (a == 7'h60) begin
            if (d[31:16] == m_key)
                for (int i = 0; i < NS; i++) if (m_lk[i] && m_c[i] == d[11:8]) m_free(i);
        end else if (a == 7'h61) begin
            m_key = d[31:16];
        end
        chk("R10 irq after write", 32'(irq), exp_irq());
    endtask

    task automatic bus_rd(input logic [3:0] mid, input logic [6:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_master = mid;
        @(posedge clk); #1;
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_main(input string tag, int i);
        logic [31:0] d;
        bus_rd(4'd0, 7'(i), d);
        chk(tag, d, img(i));
    endtask

    task automatic rd_isr_all(input string tag);
        logic [31:0] d;
        for (int c = 0; c < NC; c++) begin
            bus_rd(4'd0, 7'(7'h42 + 4*c), d);
            chk(tag, d, m_isr[c]);
        end
    endtask

    initial begin
        logic [31:0] d;
        logic [3:0]  mid;
        for (int i = 0; i < NS; i++) begin m_lk[i] = 0; m_c[i] = 0; m_p[i] = 0; end
        for (int c = 0; c < NC; c++) begin m_ier[c] = 0; m_isr[c] = 0; end
        m_key = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq", 32'(irq), 32'h0);
        for (int i = 0; i < NS; i++) rd_main("R1 free", i);
        bus_rd(4'd0, 7'h61, d); chk("R1 key", d, 32'h0);
        rd_isr_all("R1 status");

        // R7: key register
        bus_wr(4'd1, 7'h61, 32'hA5C3_FFFF);
        bus_rd(4'd2, 7'h61, d); chk("R7 key readback", d, 32'hA5C3_0000);

        // R9: enables
        bus_wr(4'd0, 7'h40, 32'hFFFF_FFFF);
        bus_wr(4'd0, 7'h44, 32'h5555_5555);
        bus_wr(4'd0, 7'h48, 32'h0000_0000);
        bus_wr(4'd0, 7'h4C, 32'hF0F0_F0F0);
        for (int c = 0; c < NC; c++) begin
            bus_rd(4'd0, 7'(7'h40 + 4*c), d); chk("R9 enable readback", d, m_ier[c]);
        end

        // R2: two-step lock of slots 0..23
        for (int i = 0; i < 24; i++) begin
            bus_wr(4'(i % 4), 7'(i), {1'b1, 23'h0, 8'((i*37 + 5) & 8'hFF)});
            rd_main("R2 two-step", i);
        end

        // R3: foreign lock writes ignored
        for (int i = 0; i < 24; i++) begin
            bus_wr(4'((i + 1) % 4), 7'(i), 32'h8000_0077);
            rd_main("R3 held ignored", i);
        end

        // R4/R5: one-step reads over held and free slots
        for (int i = 16; i < NS; i++) begin
            mid = (i % 3 == 0) ? 4'd9 : 4'(i % 4);
            if (m_lk[i]) begin
                bus_rd(mid, 7'(7'h20 + i), d);
                chk("R5 one-step held", d, img(i));
            end else begin
                bus_rd(mid, 7'(7'h20 + i), d);
                m_lk[i] = 1'b1; m_c[i] = mid; m_p[i] = 8'h0;
                chk("R4 one-step free", d, {1'b1, 19'h0, mid, 8'h00});
            end
            rd_main("R4 state after one-step", i);
        end

        // R6: mismatched unlocks leave state
        for (int i = 0; i < 8; i++) begin
            bus_wr(m_c[i], 7'(i), {24'h0, m_p[i] ^ 8'h01});
            rd_main("R6 wrong pid", i);
            bus_wr(m_c[i] ^ 4'h1, 7'(i), {24'h0, m_p[i]});
            rd_main("R6 wrong master", i);
        end
        // R6: matched unlocks free
        for (int i = 0; i < 8; i++) begin
            bus_wr(m_c[i], 7'(i), {24'h0, m_p[i]});
            rd_main("R6 owner unlock", i);
        end
        rd_isr_all("R9 status after unlock");

        // R10: write-1-to-clear
        bus_wr(4'd0, 7'h41, 32'h0000_000F);
        bus_wr(4'd0, 7'h4D, 32'hFFFF_FFFF);
        rd_isr_all("R10 status after clear");

        // R8: bulk clear with wrong key, then right key
        bus_wr(4'd3, 7'h60, 32'h1234_0200);
        for (int i = 0; i < NS; i++) rd_main("R8 wrong key", i);
        bus_wr(4'd3, 7'h60, 32'hA5C3_0200);
        for (int i = 0; i < NS; i++) rd_main("R8 right key", i);
        bus_wr(4'd3, 7'h60, 32'hA5C3_0900);
        for (int i = 0; i < NS; i++) rd_main("R8 core 9", i);
        rd_isr_all("R9 status after bulk");

        // R10: clear everything
        for (int c = 0; c < NC; c++) bus_wr(4'd0, 7'(7'h41 + 4*c), 32'hFFFF_FFFF);
        rd_isr_all("R10 all cleared");
        chk("R10 irq low", 32'(irq), 32'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule